// File: doc/BRIEF.md
# Digital Lock Detector with Hysteresis

This block watches the pulses produced by a phase-frequency detector and decides whether the loop is in lock. The UP and DOWN outputs of the detector first pass through a synchronizer into a fast sample clock. On every comparison cycle the block counts how many samples see UP or DOWN high. That count is the phase-error width. A pulse ends at the first sample where both lines are low. Its width is then graded against two thresholds, both given in sample-clock cycles: it is small, in between, or large.

Lock is declared only after a run of small-error cycles with no break. A select input sets the length of that run to the short value or the long value. Once lock is declared it is held through cycles in the middle band. A single large-error cycle drops it. A pulse that stays active past the upper threshold drops lock before the pulse ends, so a line stuck high cannot keep a stale lock. A power-down input clears the detector exactly as reset does.

Top module: `lock_detect`

## Requirements
- R1: `lock_o` is active high and reads 0 from the cycle after reset until a qualifying run completes.
- R2: The error width of a comparison cycle is the number of sample clocks in which `up_i` or `dn_i` (either line, or both overlapping) is high. A pulse closes when both lines are sampled low.
- R3: With `precise_i` = 0, lock is declared after RUN_COARSE (default 3) consecutive cycles whose width is below LO_TH (default 15).
- R4: With `precise_i` = 1, lock is declared after RUN_FINE (default 5) such consecutive cycles.
- R5: While unlocked, a cycle of width LO_TH or more resets the run of good cycles to zero. A width equal to LO_TH counts as not good.
- R6: While locked, every cycle of width up to and including HI_TH (default 25) leaves lock set.
- R7: A completed cycle of width above HI_TH clears lock, and a new full run is then needed.
- R8: A pulse still active after HI_TH+1 samples clears lock before the pulse ends.
- R9: `pwr_dn` = 1 clears lock and the run count, and pulses seen while it is high are ignored. When it coincides with a verdict that would set lock, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down; clears the detector while high |
| up_i | input | 1 | Phase detector UP pulse (asynchronous) |
| dn_i | input | 1 | Phase detector DOWN pulse (asynchronous) |
| precise_i | input | 1 | Run-length select: 0 short run, 1 long run |
| lock_o | output | 1 | Registered lock indication, active high |

## Verification
Two functions can act in the same cycle: the power-down clear, and the verdict that completes a qualifying run and would set lock. The bench sends one run short by a single pulse, then closes the final pulse. It counts the synchronizer, meter and grading registers and raises `pwr_dn` for exactly the edge at which the lock register would load. Lock must stay low at that point. Four further good pulses must then still leave it low, which shows the run count was cleared. Only the fifth pulse may set it.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic [1:0] {
    V_GOOD = 2'd0,
    V_MID  = 2'd1,
    V_BAD  = 2'd2
  } verdict_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (clr) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (clr) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter #(
  parameter int W     = 5,
  parameter int HI_TH = 25
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         act_i,
  output logic         done_o,
  output logic [W-1:0] width_o,
  output logic         long_o
);
  localparam logic [W-1:0] HI_CNT  = W'(HI_TH);
  localparam logic [W-1:0] SAT_CNT = '1;

  logic         act_q;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      act_q   <= 1'b0;
      cnt     <= '0;
      done_o  <= 1'b0;
      width_o <= '0;
      long_o  <= 1'b0;
    end else begin
      act_q  <= act_i;
      done_o <= act_q & ~act_i;
      long_o <= act_i & act_q & (cnt == HI_CNT);
      if (act_q && !act_i) width_o <= cnt;
      if (act_i) begin
        if (!act_q)              cnt <= W'(1);
        else if (cnt != SAT_CNT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/err_classify.sv
module err_classify
  import lockdet_pkg::*;
#(
  parameter int W     = 5,
  parameter int LO_TH = 15,
  parameter int HI_TH = 25
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         done_i,
  input  logic [W-1:0] width_i,
  input  logic         long_i,
  output logic         ev_valid_o,
  output verdict_e     ev_kind_o
);
  localparam logic [W-1:0] LO_CNT = W'(LO_TH);
  localparam logic [W-1:0] HI_CNT = W'(HI_TH);

  always_ff @(posedge clk) begin
    if (clr) begin
      ev_valid_o <= 1'b0;
      ev_kind_o  <= V_GOOD;
    end else if (long_i) begin
      ev_valid_o <= 1'b1;
      ev_kind_o  <= V_BAD;
    end else if (done_i) begin
      ev_valid_o <= 1'b1;
      if (width_i < LO_CNT)      ev_kind_o <= V_GOOD;
      else if (width_i > HI_CNT) ev_kind_o <= V_BAD;
      else                       ev_kind_o <= V_MID;
    end else begin
      ev_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lockdet_pkg::*;
#(
  parameter int RUN_COARSE = 3,
  parameter int RUN_FINE   = 5,
  parameter int RUN_MAX    = 5,
  parameter int RUN_W      = 3
) (
  input  logic     clk,
  input  logic     clr,
  input  logic     precise_i,
  input  logic     ev_valid_i,
  input  verdict_e ev_kind_i,
  output logic     lock_o
);
  logic             lock_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   run_nx;
  logic [RUN_W:0]   need;

  assign run_nx = {1'b0, run_q} + 1'b1;
  assign need   = precise_i ? (RUN_W+1)'(RUN_FINE) : (RUN_W+1)'(RUN_COARSE);

  always_ff @(posedge clk) begin
    if (clr) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (ev_valid_i) begin
      unique case (ev_kind_i)
        V_GOOD: begin
          if (!lock_q) begin
            if (run_nx >= need) begin
              lock_q <= 1'b1;
              run_q  <= '0;
            end else begin
              run_q <= run_nx[RUN_W-1:0];
            end
          end
        end
        V_MID: begin
          if (!lock_q) run_q <= '0;
        end
        default: begin
          lock_q <= 1'b0;
          run_q  <= '0;
        end
      endcase
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/lock_detect.sv
module lock_detect
  import lockdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LO_TH       = 15,
  parameter int HI_TH       = 25,
  parameter int RUN_COARSE  = 3,
  parameter int RUN_FINE    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_dn,
  input  logic up_i,
  input  logic dn_i,
  input  logic precise_i,
  output logic lock_o
);
  localparam int WIDTH_W = $clog2(HI_TH + 2);
  localparam int RUN_MAX = (RUN_FINE > RUN_COARSE) ? RUN_FINE : RUN_COARSE;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int N_LINES = 2;

  logic               clr;
  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] sync_lines;
  logic               act;
  logic               done;
  logic               long_ev;
  logic [WIDTH_W-1:0] width;
  logic               ev_valid;
  verdict_e           ev_kind;

  assign clr       = rst | pwr_dn;
  assign raw_lines = {dn_i, up_i};

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .clr (clr),
        .d   (raw_lines[g]),
        .q   (sync_lines[g])
      );
    end
  endgenerate

  assign act = |sync_lines;

  pulse_meter #(.W(WIDTH_W), .HI_TH(HI_TH)) u_meter (
    .clk     (clk),
    .clr     (clr),
    .act_i   (act),
    .done_o  (done),
    .width_o (width),
    .long_o  (long_ev)
  );

  err_classify #(.W(WIDTH_W), .LO_TH(LO_TH), .HI_TH(HI_TH)) u_class (
    .clk        (clk),
    .clr        (clr),
    .done_i     (done),
    .width_i    (width),
    .long_i     (long_ev),
    .ev_valid_o (ev_valid),
    .ev_kind_o  (ev_kind)
  );

  lock_fsm #(
    .RUN_COARSE (RUN_COARSE),
    .RUN_FINE   (RUN_FINE),
    .RUN_MAX    (RUN_MAX),
    .RUN_W      (RUN_W)
  ) u_fsm (
    .clk        (clk),
    .clr        (clr),
    .precise_i  (precise_i),
    .ev_valid_i (ev_valid),
    .ev_kind_i  (ev_kind),
    .lock_o     (lock_o)
  );
endmodule

// File: rtl/lock_fsm_chk.sv
module lock_fsm_chk
  import lockdet_pkg::*;
#(
  parameter int RUN_MAX = 5,
  parameter int RUN_W   = 3
) (
  input logic             clk,
  input logic             clr,
  input logic             ev_valid,
  input verdict_e         ev_kind,
  input logic             lock,
  input logic [RUN_W-1:0] run
);
  p_clear_r9: assert property (@(posedge clk) clr |=> !lock);

  p_rise_good_r3: assert property (@(posedge clk) disable iff (clr)
    $rose(lock) |-> $past(ev_valid && ev_kind == V_GOOD));

  p_fall_bad_r7: assert property (@(posedge clk) disable iff (clr)
    $fell(lock) |-> $past(clr || (ev_valid && ev_kind == V_BAD)));

  p_hold_r6: assert property (@(posedge clk) disable iff (clr)
    (lock && !(ev_valid && ev_kind == V_BAD)) |=> lock);

  p_run_bound_r4: assert property (@(posedge clk) disable iff (clr)
    run < RUN_W'(RUN_MAX));

  p_run_idle_r5: assert property (@(posedge clk) disable iff (clr)
    lock |-> run == '0);
endmodule

bind lock_fsm lock_fsm_chk #(.RUN_MAX(RUN_MAX), .RUN_W(RUN_W)) u_chk (
  .clk      (clk),
  .clr      (clr),
  .ev_valid (ev_valid_i),
  .ev_kind  (ev_kind_i),
  .lock     (lock_q),
  .run      (run_q)
);

// File: tb/lock_detect_bench.sv
module lock_detect_bench;
  localparam int GAP = 12;
  localparam int NV  = 27;
  // entry: {sel[1:0] (1 up, 2 down, 3 both), precise, width[7:0], expected lock}
  localparam logic [11:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'd5,  1'b0},  // R3 run 1
    {2'd2, 1'b0, 8'd14, 1'b0},  // R2 down line counts, run 2
    {2'd3, 1'b0, 8'd1,  1'b1},  // R3 third good locks
    {2'd1, 1'b0, 8'd20, 1'b1},  // R6 middle band held
    {2'd2, 1'b0, 8'd25, 1'b1},  // R6 exactly HI_TH held
    {2'd1, 1'b0, 8'd26, 1'b0},  // R7 above HI_TH drops
    {2'd1, 1'b0, 8'd3,  1'b0},
    {2'd1, 1'b0, 8'd3,  1'b0},
    {2'd1, 1'b0, 8'd15, 1'b0},  // R5 equal to LO_TH clears run
    {2'd1, 1'b0, 8'd3,  1'b0},
    {2'd2, 1'b0, 8'd3,  1'b0},
    {2'd1, 1'b0, 8'd3,  1'b1},  // R3 relock after fresh run
    {2'd1, 1'b0, 8'd40, 1'b0},  // R7 long pulse drops
    {2'd1, 1'b1, 8'd2,  1'b0},  // R4 long run
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd2, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b1},  // R4 fifth good locks
    {2'd1, 1'b1, 8'd30, 1'b0},  // R7
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd20, 1'b0},  // R5 middle band while unlocked clears run
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b0},
    {2'd1, 1'b1, 8'd2,  1'b1}   // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic up_i = 1'b0;
  logic dn_i = 1'b0;
  logic precise_i = 1'b0;
  logic lock_o;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #4 clk = ~clk;

  lock_detect u_lock_detect (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn    (pwr_dn),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .precise_i (precise_i),
    .lock_o    (lock_o)
  );

  task automatic check(input logic exp, input string req);
    n_tests++;
    if (lock_o !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o=%0b expected %0b", req, lock_o, exp);
    end
  endtask

  task automatic pulse(input int width, input logic [1:0] sel);
    @(negedge clk);
    up_i = sel[0];
    dn_i = sel[1];
    repeat (width) @(negedge clk);
    up_i = 1'b0;
    dn_i = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(1'b0, "R1 during reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      precise_i = VEC[i][9];
      pulse(int'(VEC[i][8:1]), VEC[i][11:10]);
      check(VEC[i][0], $sformatf("R2-R7 vector %0d", i));
    end

    // R8: stuck line drops lock while still high
    @(negedge clk);
    up_i = 1'b1;
    repeat (20) @(negedge clk);
    check(1'b1, "R8 before upper threshold");
    repeat (15) @(negedge clk);
    check(1'b0, "R8 stuck pulse");
    up_i = 1'b0;
    repeat (GAP) @(negedge clk);
    check(1'b0, "R8 after release");

    // R9: power-down while locked
    repeat (5) pulse(2, 2'd1);
    check(1'b1, "R9 relocked");
    pwr_dn = 1'b1;
    @(negedge clk);
    pwr_dn = 1'b0;
    @(negedge clk);
    check(1'b0, "R9 clear while locked");

    // R9: pulses ignored during power-down
    pwr_dn = 1'b1;
    repeat (5) pulse(2, 2'd1);
    check(1'b0, "R9 held in power-down");
    pwr_dn = 1'b0;
    repeat (4) @(negedge clk);
    check(1'b0, "R9 after power-down");

    // R9: power-down at the same edge as the locking verdict
    repeat (4) pulse(2, 2'd1);
    @(negedge clk);
    up_i = 1'b1;
    repeat (2) @(negedge clk);
    up_i = 1'b0;
    repeat (4) @(negedge clk);
    pwr_dn = 1'b1;
    @(negedge clk);
    pwr_dn = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, "R9 coincident clear wins");
    repeat (4) pulse(2, 2'd1);
    check(1'b0, "R9 run was cleared");
    pulse(2, 2'd1);
    check(1'b1, "R9 full run locks again");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule